// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI controller from the module clock. A divider word carries two independent settings and a law-select bit. The linear law divides by an even ratio, 2*(N+1), where N is an 8-bit setting. The power-of-two law divides by 2^(N+1), where N is a 4-bit setting. The linear law reaches ratios up to 512. Larger ratios must use the power-of-two law. Software picks the law and the setting; the block does not derive them from a target frequency.

Each half period of the output is a whole number of module-clock cycles, so the output always has a 50% duty cycle. While the run enable is low, the serial clock rests at the clock-polarity level and the phase counter is held at zero. While the run enable is low, the block also loads the divider word and the polarity into internal registers. It ignores changes to either while it is running. Alongside the clock it emits two single-cycle strobes for the shift engine. One marks each transition away from the rest level, and the other marks each return to it.

Top module: `sclk_divgen`

## Requirements
- R1: While reset is asserted, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: On every clock edge that samples `run_en` low, `sclk` takes the value of `cpol`, and neither strobe is raised.
- R3: When bit 12 of `div_cfg` is 1 (linear law), each half period of `sclk` lasts `div_cfg[7:0]`+1 module-clock cycles, from 1 up to 256.
- R4: When bit 12 of `div_cfg` is 0 (power-of-two law), each half period lasts 2^`div_cfg[11:8]` module-clock cycles.
- R5: After `run_en` rises, the first `sclk` transition happens on the H-th clock edge that samples `run_en` high, where H is the half-period length.
- R6: While running, all half periods are equal, so the duty cycle is 50%.
- R7: `lead_stb` is high for exactly the one cycle that follows each transition of `sclk` away from the latched polarity. `trail_stb` is high for exactly the one cycle that follows each return of `sclk` to that polarity. The two strobes are never high together.
- R8: Changes to `div_cfg` and `cpol` made while `run_en` is high do not affect `sclk` until `run_en` has been sampled low.
- R9: If `run_en` drops in the middle of a half period, `sclk` returns to `cpol` on the next edge. The next run starts with a full half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High while a transfer is running |
| cpol | input | 1 | Rest level of the serial clock |
| div_cfg | input | 13 | [7:0] linear setting, [11:8] power-of-two setting, [12] law select (1 = linear) |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse after each transition away from the rest level |
| trail_stb | output | 1 | One-cycle pulse after each return to the rest level |

## Verification
The bench targets both ends of each law:
- The linear setting 0 gives a clock that toggles on every edge. A counter that is off by one there would stall or double the period.
- The linear setting 255 gives the 512 ratio. A field truncated to fewer bits would shorten it sharply.
- The power-of-two settings 0, 3 and 9 would expose a shift that is off by one as a period that is doubled or halved.

The bench also changes the divider word and the polarity in the middle of a run. A design that loaded them at any time would bend the running clock at once. Finally, the bench drops the run enable part way through a half period. A design that failed to clear its phase counter would give the next run a short first half period.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

   typedef enum logic {
      LAW_POW2   = 1'b0,
      LAW_LINEAR = 1'b1
   } div_law_e;

   // counter width able to hold the longest half period of either law
   function automatic int half_width(input int lin_w, input int exp_w);
      int exp_bits;
      exp_bits = 1 << exp_w;
      return (lin_w + 1 > exp_bits) ? lin_w + 1 : exp_bits;
   endfunction

endpackage

// File: rtl/sclkdiv_decode.sv
module sclkdiv_decode
   import sclkdiv_pkg::*;
#(
   parameter int LIN_W  = 8,
   parameter int EXP_W  = 4,
   parameter int HALF_W = 16
) (
   input  logic [LIN_W-1:0]  lin_set,
   input  logic [EXP_W-1:0]  exp_set,
   input  div_law_e          law,
   output logic [HALF_W-1:0] half_len
);

   logic [HALF_W-1:0] lin_half;
   logic [HALF_W-1:0] exp_half;

   always_comb begin
      lin_half = HALF_W'(lin_set) + HALF_W'(1);
      exp_half = HALF_W'(1) << exp_set;
      half_len = (law == LAW_LINEAR) ? lin_half : exp_half;
   end

endmodule

// File: rtl/sclkdiv_phase.sv
module sclkdiv_phase #(
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              cpol,
   input  logic [HALF_W-1:0] half_len,
   output logic              sclk,
   output logic              lead_stb,
   output logic              trail_stb
);

   logic [HALF_W-1:0] cnt;
   logic              pol_q;
   logic              wrap;

   assign wrap = (cnt == half_len - HALF_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         sclk      <= 1'b0;
         pol_q     <= 1'b0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else if (!run) begin
         cnt       <= '0;
         sclk      <= cpol;
         pol_q     <= cpol;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else if (wrap) begin
         cnt       <= '0;
         sclk      <= ~sclk;
         lead_stb  <= (sclk == pol_q);
         trail_stb <= (sclk != pol_q);
      end else begin
         cnt       <= cnt + HALF_W'(1);
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end
   end

   p_sclk_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (sclk == $past(cpol)));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!lead_stb && !trail_stb));

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < half_len);

   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_stb && trail_stb));

   p_lead_away_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |-> (sclk != pol_q));

   p_trail_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trail_stb |-> (sclk == pol_q));

endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
   import sclkdiv_pkg::*;
#(
   parameter int LIN_W   = 8,
   parameter int EXP_W   = 4,
   parameter int LIN_LSB = 0,
   parameter int EXP_LSB = 8,
   parameter int SEL_POS = 12,
   parameter int CFG_W   = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             cpol,
   input  logic [CFG_W-1:0] div_cfg,
   output logic             sclk,
   output logic             lead_stb,
   output logic             trail_stb
);

   localparam int HALF_W = half_width(LIN_W, EXP_W);

   if (LIN_LSB + LIN_W > CFG_W) begin : g_bad_lin
      $error("linear setting field exceeds divider word");
   end
   if (EXP_LSB + EXP_W > CFG_W) begin : g_bad_exp
      $error("power-of-two setting field exceeds divider word");
   end
   if (SEL_POS >= CFG_W) begin : g_bad_sel
      $error("law select bit outside divider word");
   end

   logic [HALF_W-1:0] half_new;
   logic [HALF_W-1:0] half_q;
   div_law_e          law;

   assign law = div_law_e'(div_cfg[SEL_POS]);

   sclkdiv_decode #(
      .LIN_W (LIN_W),
      .EXP_W (EXP_W),
      .HALF_W(HALF_W)
   ) u_decode (
      .lin_set (div_cfg[LIN_LSB +: LIN_W]),
      .exp_set (div_cfg[EXP_LSB +: EXP_W]),
      .law     (law),
      .half_len(half_new)
   );

   // divider setting is captured only while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= HALF_W'(1);
      end else if (!run_en) begin
         half_q <= half_new;
      end
   end

   sclkdiv_phase #(
      .HALF_W(HALF_W)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_en),
      .cpol     (cpol),
      .half_len (half_q),
      .sclk     (sclk),
      .lead_stb (lead_stb),
      .trail_stb(trail_stb)
   );

   p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> $stable(half_q));

endmodule

// File: tb/sclk_divgen_tb.sv
module sclk_divgen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        cpol = 1'b0;
   logic [12:0] div_cfg = '0;
   logic        sclk;
   logic        lead_stb;
   logic        trail_stb;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   string cur_tag = "R1";

   // reference model state
   int m_half = 1;
   int m_t    = 0;
   int m_pol  = 0;
   int m_sclk = 0;
   int m_lead = 0;
   int m_trail = 0;

   always #5 clk = ~clk;

   sclk_divgen u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .cpol     (cpol),
      .div_cfg  (div_cfg),
      .sclk     (sclk),
      .lead_stb (lead_stb),
      .trail_stb(trail_stb)
   );

   function automatic int half_of(input logic [12:0] w);
      if (w[12]) return int'(w[7:0]) + 1;
      return 1 << w[11:8];
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_sclk = 0; m_lead = 0; m_trail = 0; m_t = 0; m_pol = 0; m_half = 1;
      end else if (!run_en) begin
         m_pol = int'(cpol);
         m_half = half_of(div_cfg);
         m_t = 0;
         m_sclk = m_pol; m_lead = 0; m_trail = 0;
      end else begin
         m_t++;
         if (m_t % m_half == 0) begin
            m_sclk  = m_pol ^ ((m_t / m_half) & 1);
            m_lead  = ((m_t / m_half) & 1);
            m_trail = 1 - m_lead;
         end else begin
            m_lead = 0; m_trail = 0;
         end
      end
   end

   task automatic check_bit(input string what, input logic act, input int exp);
      checks++;
      if (int'(act) != exp) begin
         errors++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                  cur_tag, what, cycles, act, exp);
      end
   endtask

   always @(negedge clk) begin
      check_bit("sclk", sclk, m_sclk);
      check_bit("lead_stb", lead_stb, m_lead);
      check_bit("trail_stb", trail_stb, m_trail);
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic burst(input logic [12:0] w, input logic pol, input int n, input string tag);
      cur_tag = tag;
      run_en  = 1'b0;
      div_cfg = w;
      cpol    = pol;
      wait_cyc(2);
      run_en = 1'b1;
      wait_cyc(n);
      run_en = 1'b0;
      wait_cyc(2);
   endtask

   initial begin
      cur_tag = "R1";
      wait_cyc(3);
      rst_n = 1'b1;
      cur_tag = "R2";
      cpol = 1'b1;
      wait_cyc(3);
      cpol = 1'b0;
      wait_cyc(3);
      // linear law, toggle every cycle
      burst(13'h1000, 1'b0, 20, "R3 R5 R6 R7");
      // linear law, half period 5, high rest level
      burst(13'h1004, 1'b1, 60, "R3 R5 R7");
      // power-of-two law settings 0, 3, 9
      burst(13'h0000, 1'b0, 10, "R4 R5");
      burst(13'h0300, 1'b1, 80, "R4 R6 R7");
      burst(13'h0900, 1'b0, 2100, "R4 R6");
      // linear maximum, ratio 512
      burst(13'h10FF, 1'b0, 1100, "R3 R6");
      // mid-run changes of setting and polarity are ignored
      cur_tag = "R8";
      div_cfg = 13'h1002; cpol = 1'b0;
      wait_cyc(2);
      run_en = 1'b1;
      wait_cyc(7);
      div_cfg = 13'h0500; cpol = 1'b1;
      wait_cyc(40);
      run_en = 1'b0;
      wait_cyc(3);
      // run dropped in the middle of a half period
      cur_tag = "R9";
      div_cfg = 13'h1005; cpol = 1'b0;
      wait_cyc(2);
      run_en = 1'b1;
      wait_cyc(9);
      run_en = 1'b0;
      wait_cyc(1);
      run_en = 1'b1;
      wait_cyc(30);
      run_en = 1'b0;
      wait_cyc(3);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule